// File: doc/BRIEF.md
# Two-Tier Chained Bus Arbiter

This block decides which of several potential bus masters may own a shared bus. Each master belongs to exactly one priority tier. Every tier has one shared request line, formed from the requests of its members, and one grant line. The central selector drives a grant onto the highest-priority tier that is requesting. Inside that tier the grant runs along a chain of cells in ascending master index, so the lowest index is the nearest to the selector. A cell whose master is requesting keeps the grant. A cell whose master is idle passes the grant to the next member.

The winning master holds the bus through a shared busy flag until it signals completion on its own done pin. While the flag is up, no tier receives a grant. Requests may change in any cycle. The grant is a one-hot vector that responds combinationally to the requests of the current cycle. Busy is registered: it rises one cycle after a grant and falls one cycle after the owner's done. The default configuration has four masters in two tiers, with masters 0 and 2 in tier 0 and masters 1 and 3 in tier 1. All pins are plain control pins, so there is no back-pressure protocol.

Top module: `ml_chain_arbiter`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset when no request is present, `busy` is 0 and `gnt` is all zeros.
- R2: `gnt[i]` is only ever 1 in a cycle in which `req[i]` is 1 and `busy` is 0.
- R3: Within one tier, among the requesting members, the grant goes to the member with the lowest index. Idle members pass the grant on.
- R4: Tier 0 outranks tier 1. If any tier-0 master requests while the bus is free, no tier-1 master is granted. Master i belongs to tier `LEVEL_MAP[i]`, and the default value 4'b1010 puts masters 1 and 3 in tier 1.
- R5: When a grant is issued, `busy` is 1 from the next cycle on. It stays 1 until a rising edge at which the owning master's `done` is 1.
- R6: While `busy` is 1, `gnt` is all zeros, whatever the requests are.
- R7: A `done` pulse from a master that does not own the bus has no effect, and `busy` remains 1.
- R8: At most one bit of `gnt` is 1 in any cycle.
- R9: After the owner's `done` is sampled, `busy` is 0 in the next cycle, and a pending request is granted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MASTERS | Per-master bus request |
| done | input | N_MASTERS | Per-master end-of-transaction strobe; only the owner's bit counts |
| gnt | output | N_MASTERS | One-hot grant, combinational from `req` and the busy state |
| busy | output | 1 | Bus owned by a master |

## Verification
Random request vectors with a bias toward many simultaneous requesters check the tier ranking against the chain ordering. A vector containing both tiers exposes any reversal of tier priority. A vector with only a high-index member of one tier exposes a chain that fails to pass the grant through idle cells. Random done strobes, including strobes from masters that do not own the bus, separate correct release by the owner from release by any master. Directed cases cover the full-request vector, a request held across the busy window, and a new grant in the cycle after release.

// File: rtl/ml_arb_pkg.sv
package ml_arb_pkg;
  typedef enum logic {
    BUS_FREE = 1'b0,
    BUS_HELD = 1'b1
  } bus_state_e;
endpackage

// File: rtl/ml_tier_select.sv
module ml_tier_select #(
  parameter int N_LEVELS = 2
) (
  input  logic [N_LEVELS-1:0] lvl_req,
  input  logic                busy,
  output logic [N_LEVELS-1:0] lvl_gnt
);
  // Fixed priority: tier 0 first.
  always_comb begin
    logic found;
    found   = 1'b0;
    lvl_gnt = '0;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (!found && lvl_req[l] && !busy) begin
        lvl_gnt[l] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ml_chain_cell.sv
module ml_chain_cell #(
  parameter bit IS_MEMBER = 1'b1
) (
  input  logic grant_in,
  input  logic req,
  output logic grant_out,
  output logic take
);
  generate
    if (IS_MEMBER) begin : g_member
      assign take      = grant_in & req;
      assign grant_out = grant_in & ~req;
    end else begin : g_bypass
      assign take      = 1'b0;
      assign grant_out = grant_in;
    end
  endgenerate
endmodule

// File: rtl/ml_busy_track.sv
module ml_busy_track
  import ml_arb_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] gnt,
  input  logic [N_MASTERS-1:0] done,
  output logic                 busy
);
  logic [N_MASTERS-1:0] owner_q;
  bus_state_e           state;

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= '0;
    else        owner_q <= (owner_q & ~done) | gnt;
  end

  assign state = (|owner_q) ? BUS_HELD : BUS_FREE;
  assign busy  = (state == BUS_HELD);

  p_busy_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> busy);
  p_owner_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(owner_q & done)) |=> !busy);
  p_foreign_done_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(|(owner_q & done))) |=> busy);
  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_q));
endmodule

// File: rtl/ml_chain_arbiter.sv
module ml_chain_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int N_LEVELS  = 2,
  parameter int LW        = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1,
  parameter logic [N_MASTERS*LW-1:0] LEVEL_MAP = 4'b1010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] done,
  output logic [N_MASTERS-1:0] gnt,
  output logic                 busy
);
  logic [N_LEVELS-1:0]                 lvl_req;
  logic [N_LEVELS-1:0]                 lvl_gnt;
  logic [N_LEVELS-1:0][N_MASTERS:0]    chain;
  logic [N_MASTERS-1:0][N_LEVELS-1:0]  take;

  // Shared request line of each tier.
  always_comb begin
    lvl_req = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      for (int l = 0; l < N_LEVELS; l++) begin
        if (LEVEL_MAP[i*LW +: LW] == LW'(l)) lvl_req[l] = lvl_req[l] | req[i];
      end
    end
  end

  ml_tier_select #(.N_LEVELS(N_LEVELS)) u_sel (
    .lvl_req (lvl_req),
    .busy    (busy),
    .lvl_gnt (lvl_gnt)
  );

  // One chain per tier; cells of other tiers are transparent.
  for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
    assign chain[l][0] = lvl_gnt[l];
    for (genvar i = 0; i < N_MASTERS; i++) begin : g_cell
      ml_chain_cell #(.IS_MEMBER(LEVEL_MAP[i*LW +: LW] == LW'(l))) u_cell (
        .grant_in  (chain[l][i]),
        .req       (req[i]),
        .grant_out (chain[l][i+1]),
        .take      (take[i][l])
      );
    end
  end

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_out
    assign gnt[i] = |take[i];
  end

  ml_busy_track #(.N_MASTERS(N_MASTERS)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .gnt   (gnt),
    .done  (done),
    .busy  (busy)
  );

  p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_no_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gnt == '0));
  p_tier_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_gnt));
endmodule

// File: tb/ml_chain_arbiter_tb.sv
module ml_chain_arbiter_tb_top;
  localparam int N = 4;
  localparam logic [N-1:0] MAP = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] gnt;
  logic busy;

  int total = 0;
  int bad = 0;
  int own = -1;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ml_chain_arbiter #(.N_MASTERS(N), .N_LEVELS(2), .LEVEL_MAP(MAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .gnt(gnt), .busy(busy)
  );

  function automatic logic [N-1:0] exp_gnt(logic [N-1:0] r, bit b);
    if (b) return '0;
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < N; i++)
        if (MAP[i] == l[0] && r[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, check before the next posedge, then update the model.
  task automatic step(logic [N-1:0] r, logic [N-1:0] d, string tag);
    logic [N-1:0] eg;
    @(negedge clk);
    req = r; done = d;
    #1;
    chk({tag, " R5 R6 R7 busy"}, N'(busy), N'(own >= 0));
    eg = exp_gnt(r, own >= 0);
    chk({tag, " R2 R3 R4 gnt"}, gnt, eg);
    if ($countones(gnt) > 1) chk("R8 onehot", gnt, eg);
    @(posedge clk);
    if (eg != '0) begin
      for (int i = 0; i < N; i++) if (eg[i]) own = i;
    end else if (own >= 0 && d[own]) own = -1;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset gnt", gnt, '0);
    chk("R1 reset busy", N'(busy), '0);
    rst_n = 1'b1;
    // Directed: both tiers request, master 0 wins (R4, R3).
    step(4'b1111, 4'b0000, "dir-all");
    chk("R4 winner master0", N'(own), N'(0));
    // Held request while busy: no grant (R6); foreign done ignored (R7).
    step(4'b1110, 4'b1000, "dir-foreign-done");
    step(4'b1110, 4'b0000, "dir-held");
    // Owner done, then next cycle tier 1 only: master1 wins (R9, R3).
    step(4'b1010, 4'b0001, "dir-release");
    step(4'b1010, 4'b0000, "dir-R9-regrant");
    chk("R9 new owner master1", N'(own), N'(1));
    step(4'b0000, 4'b0010, "dir-release2");
    // Chain passes through idle cells: only master 3 of tier 1 (R3).
    step(4'b1000, 4'b0000, "dir-R3-pass");
    chk("R3 pass-through master3", N'(own), N'(3));
    step(4'b0000, 4'b1000, "dir-release3");
    // Only master 2 of tier 0 versus master 1 of tier 1 (R4).
    step(4'b0110, 4'b0000, "dir-R4-tier");
    chk("R4 tier0 master2", N'(own), N'(2));
    step(4'b0000, 4'b0100, "dir-release4");
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r;
      logic [N-1:0] d;
      r = N'($urandom) | (($urandom % 3 == 0) ? N'($urandom) : '0);
      d = ($urandom % 4 == 0) ? N'($urandom) : '0;
      step(r, d, "rand");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule